// File: doc/BRIEF.md
# Port Jabber and Partition Guard

This block watches a single port of a multi-port repeater and decides whether that port must be cut off from the shared medium. A repeater instantiates one copy per port. Two faults are tracked. The first is a receive that never ends, called jabber. The second is a port that keeps colliding, called partition. Either fault raises a status flag, and the repeater core uses that flag to mask the port's receive and transmit paths. Every other port keeps running as before.

Bit time is counted inside the block. In fast mode each core clock is one 25 MHz nibble period, worth four bit times. In slow mode only the clocks with the bit tick input high count, and each of those adds one bit time. The jabber timer runs while carrier is present and starts again from zero on each new carrier. An activity window is open whenever the port is receiving or transmitting. A window that sees any collision counts as one collision event. A window that stays clean long enough clears the count. After enough consecutive collision events the port is partitioned. It is reconnected only by a clean transmission longer than the reconnect length. A configuration strap can hold the port partitioned.

Top module: `port_isolation_guard`

## Requirements
- R1: With `speed_fast`=1, each clock in which `crs`=1 adds 4 bit times to the jabber timer. `jabber` goes high after the edge where the total first exceeds JAB_BITS (65536). That is the 16385th consecutive carrier clock; after 16384 clocks the flag is still low.
- R2: With `speed_fast`=0, the timer advances by 1 only on clocks where `bit_tick`=1. Carrier clocks with `bit_tick`=0 do not advance it.
- R3: `jabber` clears on the first edge that samples `crs`=0. A new carrier restarts the timer from zero.
- R4: `port_off` is high exactly when `jabber` or `partition` is high.
- R5: An activity window is a run of clocks with `crs`=1 or `tx_act`=1. A window with `col`=1 on any of its clocks counts as one collision event, however many collision pulses it holds. When the count reaches COL_LIMIT (64), `partition` goes high, and further collisions keep it high.
- R6: A window that stays collision-free for at least CLEAN_BITS (512) bit times resets the collision count to zero. A receive-only window does this without releasing an existing partition.
- R7: A partitioned port is released only by a collision-free window with `tx_act`=1 that exceeds CLEAN_BITS bit times. In fast mode `partition` is still high after 128 such clocks and is low after 129.
- R8: While `force_part`=1, `partition` is high from the next edge on, and no clean transmission releases it.
- R9: Asserting `rst_n` low clears `jabber`, `partition` and all history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock (nibble clock in fast mode) |
| rst_n | input | 1 | Asynchronous reset, active low |
| speed_fast | input | 1 | 1: four bit times per clock; 0: one bit time per `bit_tick` |
| bit_tick | input | 1 | Bit-time strobe used in slow mode |
| crs | input | 1 | Carrier sense of the port |
| col | input | 1 | Collision indication for the port |
| tx_act | input | 1 | Repeater is transmitting onto the port |
| force_part | input | 1 | Strap that holds the port partitioned |
| jabber | output | 1 | Jabber status flag |
| partition | output | 1 | Partition status flag |
| port_off | output | 1 | Port isolated (receive and transmit masked) |

## Verification
The properties assume that all inputs are synchronous to `clk` and that a collision is reported only while the port is active. The stimulus changes every input on the falling edge only. It raises `col` only inside a window that already has `crs` high, and it never holds `force_part` across a reset release. The strap is treated as a level that may change at any clock. The release property relies on the repeater asserting `tx_act` for the whole reconnecting transmission, and the bench drives transmit windows as a solid run of `tx_act`.

// File: rtl/guard_pkg.sv
package guard_pkg;
    localparam int unsigned DEF_JAB_BITS   = 65536;
    localparam int unsigned DEF_CLEAN_BITS = 512;
    localparam int unsigned DEF_COL_LIMIT  = 64;
    localparam int unsigned DEF_NIB_BITS   = 4;
endpackage

// File: rtl/bit_advance.sv
module bit_advance #(
    parameter int unsigned NIB_BITS = 4,
    parameter int unsigned ADV_W    = 3
) (
    input  logic             speed_fast,
    input  logic             bit_tick,
    output logic [ADV_W-1:0] adv
);
    always_comb begin
        if (speed_fast)
            adv = ADV_W'(NIB_BITS);
        else if (bit_tick)
            adv = ADV_W'(1);
        else
            adv = '0;
    end
endmodule

// File: rtl/jabber_timer.sv
module jabber_timer #(
    parameter int unsigned LIMIT = 65536,
    parameter int unsigned STEP  = 4,
    parameter int unsigned ADV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             crs,
    input  logic [ADV_W-1:0] adv,
    output logic             jabber
);
    localparam int unsigned CAP = LIMIT + STEP;
    localparam int unsigned CW  = $clog2(CAP + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          jab;
    } jab_st_t;

    jab_st_t st_q, st_d;
    logic [CW:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = '0;
        if (!crs) begin
            st_d = '0;
        end else begin
            sum = {1'b0, st_q.cnt} + (CW+1)'(adv);
            if (sum > (CW+1)'(CAP))
                sum = (CW+1)'(CAP);
            st_d.cnt = sum[CW-1:0];
            st_d.jab = st_q.jab | (sum > (CW+1)'(LIMIT));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign jabber = st_q.jab;
endmodule

// File: rtl/collision_tracker.sv
module collision_tracker #(
    parameter int unsigned CLEAN     = 512,
    parameter int unsigned STEP      = 4,
    parameter int unsigned COL_LIMIT = 64,
    parameter int unsigned ADV_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             crs,
    input  logic             tx_act,
    input  logic             col,
    input  logic             force_part,
    input  logic [ADV_W-1:0] adv,
    output logic             partition
);
    localparam int unsigned LCAP = CLEAN + STEP;
    localparam int unsigned LW   = $clog2(LCAP + 1);
    localparam int unsigned NW   = $clog2(COL_LIMIT + 1);

    typedef struct packed {
        logic [LW-1:0] len;
        logic          seen;
        logic [NW-1:0] cnt;
        logic          part;
    } col_st_t;

    col_st_t st_q, st_d;
    logic [LW:0] lsum;
    logic        act;

    always_comb begin
        st_d = st_q;
        act  = crs | tx_act;
        lsum = {1'b0, st_q.len} + (LW+1)'(adv);
        if (lsum > (LW+1)'(LCAP))
            lsum = (LW+1)'(LCAP);
        if (!act) begin
            st_d.len  = '0;
            st_d.seen = 1'b0;
        end else begin
            st_d.len = lsum[LW-1:0];
            if (col && !st_q.seen) begin
                st_d.seen = 1'b1;
                if (st_q.cnt != NW'(COL_LIMIT))
                    st_d.cnt = st_q.cnt + NW'(1);
                if (st_q.cnt >= NW'(COL_LIMIT - 1))
                    st_d.part = 1'b1;
            end else if (!st_q.seen && !col) begin
                if (lsum >= (LW+1)'(CLEAN))
                    st_d.cnt = '0;
                if (tx_act && (lsum > (LW+1)'(CLEAN)))
                    st_d.part = 1'b0;
            end
        end
        if (force_part)
            st_d.part = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign partition = st_q.part;
endmodule

// File: rtl/port_isolation_guard.sv
module port_isolation_guard
    import guard_pkg::*;
#(
    parameter int unsigned JAB_BITS   = DEF_JAB_BITS,
    parameter int unsigned CLEAN_BITS = DEF_CLEAN_BITS,
    parameter int unsigned COL_LIMIT  = DEF_COL_LIMIT,
    parameter int unsigned NIB_BITS   = DEF_NIB_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic speed_fast,
    input  logic bit_tick,
    input  logic crs,
    input  logic col,
    input  logic tx_act,
    input  logic force_part,
    output logic jabber,
    output logic partition,
    output logic port_off
);
    localparam int unsigned ADV_W = $clog2(NIB_BITS + 1);

    logic [ADV_W-1:0] adv;

    bit_advance #(.NIB_BITS(NIB_BITS), .ADV_W(ADV_W)) u_adv (
        .speed_fast (speed_fast),
        .bit_tick   (bit_tick),
        .adv        (adv)
    );

    jabber_timer #(.LIMIT(JAB_BITS), .STEP(NIB_BITS), .ADV_W(ADV_W)) u_jab (
        .clk    (clk),
        .rst_n  (rst_n),
        .crs    (crs),
        .adv    (adv),
        .jabber (jabber)
    );

    collision_tracker #(
        .CLEAN(CLEAN_BITS), .STEP(NIB_BITS), .COL_LIMIT(COL_LIMIT), .ADV_W(ADV_W)
    ) u_col (
        .clk        (clk),
        .rst_n      (rst_n),
        .crs        (crs),
        .tx_act     (tx_act),
        .col        (col),
        .force_part (force_part),
        .adv        (adv),
        .partition  (partition)
    );

    assign port_off = jabber | partition;
endmodule

// File: rtl/guard_chk.sv
module guard_chk (
    input logic clk,
    input logic rst_n,
    input logic crs,
    input logic col,
    input logic tx_act,
    input logic force_part,
    input logic jabber,
    input logic partition
);
    // R3
    jab_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !crs |=> !jabber);

    // R1
    jab_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jabber |-> $past(crs));

    // R8
    force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_part |=> partition);

    // R7
    part_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(partition) |-> ($past(tx_act) && !$past(force_part)));

    // R5
    part_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(partition) |-> ($past(col) || $past(force_part)));
endmodule

bind port_isolation_guard guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .crs        (crs),
    .col        (col),
    .tx_act     (tx_act),
    .force_part (force_part),
    .jabber     (jabber),
    .partition  (partition)
);

// File: tb/sim_port_isolation_guard.sv
module sim_port_isolation_guard;
    localparam int CLK_NS = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic speed_fast = 1'b1;
    logic bit_tick = 1'b0;
    logic crs = 1'b0;
    logic col = 1'b0;
    logic tx_act = 1'b0;
    logic force_part = 1'b0;
    logic jabber, partition, port_off;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string tag;
        logic  j;
        logic  p;
        logic  o;
    } exp_t;

    exp_t sb[$];
    event chk_ev;

    always #(CLK_NS/2) clk = ~clk;

    port_isolation_guard u0 (
        .clk(clk), .rst_n(rst_n), .speed_fast(speed_fast), .bit_tick(bit_tick),
        .crs(crs), .col(col), .tx_act(tx_act), .force_part(force_part),
        .jabber(jabber), .partition(partition), .port_off(port_off)
    );

    // monitor: compares what the design shows against queued expectations
    initial begin
        forever begin
            @(chk_ev);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (jabber !== e.j || partition !== e.p || port_off !== e.o) begin
                    errors++;
                    $display("FAIL %s: jabber/partition/port_off got %b%b%b expected %b%b%b",
                             e.tag, jabber, partition, port_off, e.j, e.p, e.o);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side: push expectation (port_off from R4) and wake the monitor
    task automatic expect_out(input string tag, input logic j, input logic p);
        exp_t e;
        e.tag = tag;
        e.j = j;
        e.p = p;
        e.o = j | p;
        sb.push_back(e);
        ->chk_ev;
        #1;
    endtask

    task automatic col_window(input int pulses);
        crs = 1'b1;
        cyc(1);
        repeat (pulses) begin
            col = 1'b1;
            cyc(1);
            col = 1'b0;
            cyc(1);
        end
        crs = 1'b0;
        cyc(1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(2);
        expect_out("R9 reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        cyc(1);
    endtask

    initial begin
        cyc(2);
        expect_out("R9 reset state", 1'b0, 1'b0);
        rst_n = 1'b1;
        cyc(1);

        // R1: fast-mode jabber boundary
        crs = 1'b1;
        cyc(16384);
        expect_out("R1 at 65536 bits", 1'b0, 1'b0);
        cyc(1);
        expect_out("R1 past limit", 1'b1, 1'b0);
        // R3: clears when carrier drops
        crs = 1'b0;
        cyc(1);
        expect_out("R3 carrier drop", 1'b0, 1'b0);
        // R3: restart from zero on new carrier
        crs = 1'b1;
        cyc(16384);
        expect_out("R3 restart", 1'b0, 1'b0);
        crs = 1'b0;
        cyc(1);

        // R2: slow mode advances on tick only
        speed_fast = 1'b0;
        crs = 1'b1;
        cyc(5000);
        expect_out("R2 no tick", 1'b0, 1'b0);
        bit_tick = 1'b1;
        cyc(65536);
        expect_out("R2 ticks at limit", 1'b0, 1'b0);
        cyc(1);
        expect_out("R2 ticks past limit", 1'b1, 1'b0);
        crs = 1'b0;
        bit_tick = 1'b0;
        speed_fast = 1'b1;
        cyc(1);
        expect_out("R3 slow drop", 1'b0, 1'b0);

        // R5: multi-pulse window counts once
        for (int i = 0; i < 62; i++) col_window(1);
        col_window(3);
        expect_out("R5 63 events", 1'b0, 1'b0);
        col_window(1);
        expect_out("R5 64th event", 1'b0, 1'b1);
        col_window(2);
        expect_out("R5 stays partitioned", 1'b0, 1'b1);

        // R6: clean receive does not release
        crs = 1'b1;
        cyc(200);
        crs = 1'b0;
        cyc(1);
        expect_out("R6 rx no release", 1'b0, 1'b1);

        // R7: release boundary
        tx_act = 1'b1;
        cyc(128);
        expect_out("R7 512 bits", 1'b0, 1'b1);
        cyc(1);
        expect_out("R7 516 bits", 1'b0, 1'b0);
        tx_act = 1'b0;
        cyc(1);

        // R6: clean window clears count
        for (int i = 0; i < 63; i++) col_window(1);
        expect_out("R6 63 before clean", 1'b0, 1'b0);
        crs = 1'b1;
        cyc(128);
        crs = 1'b0;
        cyc(1);
        for (int i = 0; i < 63; i++) col_window(1);
        expect_out("R6 63 after clean", 1'b0, 1'b0);
        col_window(1);
        expect_out("R6 64 after clean", 1'b0, 1'b1);

        // R9: reset clears partition
        do_reset();

        // R8: strap
        force_part = 1'b1;
        cyc(1);
        expect_out("R8 forced", 1'b0, 1'b1);
        tx_act = 1'b1;
        cyc(200);
        tx_act = 1'b0;
        cyc(1);
        expect_out("R8 no release while forced", 1'b0, 1'b1);
        force_part = 1'b0;
        cyc(1);
        expect_out("R8 strap removed", 1'b0, 1'b1);
        tx_act = 1'b1;
        cyc(200);
        tx_act = 1'b0;
        cyc(1);
        expect_out("R8 release after strap", 1'b0, 1'b0);

        // R4: jabber and partition together
        force_part = 1'b1;
        crs = 1'b1;
        cyc(16385);
        expect_out("R4 both set", 1'b1, 1'b1);
        crs = 1'b0;
        force_part = 1'b0;
        cyc(2);
        do_reset();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_NS * 195000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule